// File: doc/BRIEF.md
# Memory access attribute decoder

This block sits beside a CPU's load/store path and gives each data address a destination. Each request is sorted into one of four classes. A cached DRAM access goes to the cache. An uncached DRAM access bypasses the cache. A PCI-forwarded access goes to the bus master. A suppressed access never leaves the core: a suppressed load returns zero and a suppressed store is discarded.

Two writable settings steer the decision. The first is a cacheable limit held with 64 KB granularity. DRAM addresses from that limit up to the DRAM limit form a single uncached window at the top of the DRAM aperture. The second is a 2-bit aperture mode held in bits 6:5 of a control word. The mode opens or closes a low-address hole and can switch PCI forwarding off entirely. The DRAM base and limit come from a neighbouring configuration block.

Each decision appears on the outputs one clock after the request is accepted. The outputs are the route code, a force-zero-read flag and a drop-store flag.

Top module: `mem_attr_decode`

## Requirements
- R1: After reset the cacheable limit equals `dram_limit_i`, so the uncached window is empty and every DRAM address routes cached. The aperture mode is 00 and `rsp_valid` is 0.
- R2: A request with `req_valid` high produces exactly one response with `rsp_valid` high in the next cycle. Without a request, no response appears.
- R3: The route code is 0 for cached, 1 for uncached, 2 for PCI and 3 for suppressed. An address in [`dram_base_i`, `dram_limit_i`) routes uncached when it is at or above the cacheable limit, and cached below it. An address at or above `dram_limit_i` never routes to DRAM.
- R4: A configuration write with `cfg_sel`=0 sets the cacheable limit to `cfg_wdata` with bits 15:0 forced to zero.
- R5: In mode 00, a load to address 0x00..0xFF outside DRAM is suppressed with the zero-read flag set. A store to that range goes to PCI.
- R6: In mode 01, loads to 0x00..0xFF are forwarded to PCI.
- R7: In mode 10, every access outside DRAM is suppressed. Loads set the zero-read flag only, stores set the drop-store flag only, and DRAM accesses are unaffected.
- R8: Mode 11 decodes exactly as mode 00.
- R9: In modes 00, 01 and 11, addresses outside DRAM and outside 0x00..0xFF route to PCI with both flags clear.
- R10: A configuration write with `cfg_sel`=1 takes the mode from `cfg_wdata[6:5]` and ignores every other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dram_base_i | input | 32 | First byte address of DRAM |
| dram_limit_i | input | 32 | First byte above DRAM, 64 KB aligned |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0: cacheable limit, 1: control word |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Request byte address |
| req_is_store | input | 1 | 1 for store, 0 for load |
| rsp_valid | output | 1 | Decision present |
| rsp_route | output | 2 | Route code (see R3) |
| rsp_zero_read | output | 1 | Load must return zero without a bus read |
| rsp_drop_store | output | 1 | Store must be discarded |

## Verification
The assertions assume that `dram_base_i` lies above the 0x00..0xFF hole, that `dram_limit_i` is 64 KB aligned, and that both are held stable once reset ends. They also assume that a configuration write and a request never meet in the same cycle. The stimulus respects all of this. It fixes the DRAM bounds for the whole run and issues every configuration write in a cycle of its own before the requests that depend on it. Requests then walk the boundaries of the uncached window, the edges of the low hole and the first address above DRAM under each of the four modes, with some back-to-back and some separated by idle cycles.

// File: rtl/mad_pkg.sv
// Shared encodings for the memory access attribute decoder.
// Assumes nothing beyond the 2-bit route and mode fields.
package mad_pkg;
    typedef enum logic [1:0] {
        ROUTE_CACHED   = 2'd0,
        ROUTE_UNCACHED = 2'd1,
        ROUTE_PCI      = 2'd2,
        ROUTE_SUPPRESS = 2'd3
    } route_t;

    typedef enum logic [1:0] {
        APM_HOLE_ON  = 2'd0,
        APM_HOLE_OFF = 2'd1,
        APM_PCI_OFF  = 2'd2,
        APM_RSVD     = 2'd3
    } apmode_t;

    localparam int CTL_MODE_LSB = 5;
endpackage

// File: rtl/mad_regs.sv
// Configuration storage: cacheable limit (upper bits only) and aperture mode.
// Assumes dram_limit_i is stable and aligned while reset is held.
module mad_regs
    import mad_pkg::*;
#(
    parameter int AW        = 32,
    parameter int GRAN_BITS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [AW-1:0] wr_data,
    input  logic [AW-1:0] dram_limit_i,
    output logic [AW-1:0] cl_limit,
    output apmode_t       mode
);
    localparam int HI_W = AW - GRAN_BITS;

    logic [HI_W-1:0] cl_hi_q;
    logic            unused_bits;

    // Purpose: hold the cacheable-limit field, reset to the DRAM limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cl_hi_q <= dram_limit_i[AW-1:GRAN_BITS];
        end else if (wr_en && !wr_sel) begin
            cl_hi_q <= wr_data[AW-1:GRAN_BITS];
        end
    end

    // Purpose: hold the aperture mode taken from the control word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= APM_HOLE_ON;
        end else if (wr_en && wr_sel) begin
            mode <= apmode_t'(wr_data[CTL_MODE_LSB+1:CTL_MODE_LSB]);
        end
    end

    assign cl_limit    = {cl_hi_q, {GRAN_BITS{1'b0}}};
    assign unused_bits = ^{wr_data[GRAN_BITS-1:CTL_MODE_LSB+2],
                           wr_data[CTL_MODE_LSB-1:0],
                           dram_limit_i[GRAN_BITS-1:0]};
endmodule

// File: rtl/mad_classify.sv
// Combinational address classifier.
// Assumes dram_base lies above the low hole; DRAM takes priority over the hole.
module mad_classify
    import mad_pkg::*;
#(
    parameter int          AW        = 32,
    parameter logic [31:0] HOLE_LAST = 32'hFF
) (
    input  logic [AW-1:0] addr,
    input  logic          is_store,
    input  logic [AW-1:0] cl_limit,
    input  logic [AW-1:0] dram_base,
    input  logic [AW-1:0] dram_limit,
    input  apmode_t       mode,
    output route_t        route,
    output logic          zero_read,
    output logic          drop_store
);
    localparam logic [AW-1:0] HOLE_END = AW'(HOLE_LAST);

    logic in_dram, in_hole, pci_off, hole_on;

    assign in_dram = (addr >= dram_base) && (addr < dram_limit);
    assign in_hole = (addr <= HOLE_END);
    assign pci_off = (mode == APM_PCI_OFF);
    assign hole_on = (mode == APM_HOLE_ON) || (mode == APM_RSVD);

    // Purpose: choose the destination and the load/store side effects.
    always_comb begin
        route      = ROUTE_PCI;
        zero_read  = 1'b0;
        drop_store = 1'b0;
        if (in_dram) begin
            route = (addr >= cl_limit) ? ROUTE_UNCACHED : ROUTE_CACHED;
        end else if (pci_off) begin
            route      = ROUTE_SUPPRESS;
            zero_read  = !is_store;
            drop_store = is_store;
        end else if (in_hole && hole_on && !is_store) begin
            route     = ROUTE_SUPPRESS;
            zero_read = 1'b1;
        end
    end
endmodule

// File: rtl/mem_attr_decode.sv
// Top: registers configuration, classifies each request, registers the result.
// Assumes configuration writes and requests do not share a cycle, and DRAM
// bounds are stable after reset.
module mem_attr_decode
    import mad_pkg::*;
#(
    parameter int          AW        = 32,
    parameter int          GRAN_BITS = 16,
    parameter logic [31:0] HOLE_LAST = 32'hFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] dram_base_i,
    input  logic [AW-1:0] dram_limit_i,
    input  logic          cfg_wr_en,
    input  logic          cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic          req_is_store,
    output logic          rsp_valid,
    output logic [1:0]    rsp_route,
    output logic          rsp_zero_read,
    output logic          rsp_drop_store
);
    logic [AW-1:0] cl_limit;
    apmode_t       mode;
    route_t        route_c;
    logic          zero_c, drop_c;

    mad_regs #(.AW(AW), .GRAN_BITS(GRAN_BITS)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (cfg_wr_en),
        .wr_sel       (cfg_sel),
        .wr_data      (cfg_wdata),
        .dram_limit_i (dram_limit_i),
        .cl_limit     (cl_limit),
        .mode         (mode)
    );

    mad_classify #(.AW(AW), .HOLE_LAST(HOLE_LAST)) u_cls (
        .addr       (req_addr),
        .is_store   (req_is_store),
        .cl_limit   (cl_limit),
        .dram_base  (dram_base_i),
        .dram_limit (dram_limit_i),
        .mode       (mode),
        .route      (route_c),
        .zero_read  (zero_c),
        .drop_store (drop_c)
    );

    // Purpose: register the decision one cycle after an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid      <= 1'b0;
            rsp_route      <= ROUTE_CACHED;
            rsp_zero_read  <= 1'b0;
            rsp_drop_store <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_route      <= route_c;
                rsp_zero_read  <= zero_c;
                rsp_drop_store <= drop_c;
            end
        end
    end

    a_r2_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    a_r3_above_dram: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr >= dram_limit_i) |=>
        (rsp_route == ROUTE_PCI || rsp_route == ROUTE_SUPPRESS));
    a_r7_zero_is_suppress: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_zero_read) |->
        (rsp_route == ROUTE_SUPPRESS && !rsp_drop_store));
    a_r7_drop_is_suppress: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_drop_store) |-> (rsp_route == ROUTE_SUPPRESS));
endmodule

// File: tb/mem_attr_decode_bench.sv
`timescale 1ns/1ps
module mem_attr_decode_bench;
    localparam logic [31:0] DBASE  = 32'h1000_0000;
    localparam logic [31:0] DLIMIT = 32'h1100_0000;

    typedef struct {
        logic [1:0] route;
        logic       zero;
        logic       drop;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0, cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0, req_is_store = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_valid, rsp_zero_read, rsp_drop_store;
    logic [1:0]  rsp_route;

    int   n_cmp = 0, n_bad = 0;
    bit   done = 0;
    exp_t sb[$];

    logic [31:0] m_cl;
    logic [1:0]  m_mode;

    always #2.5 clk = ~clk;

    mem_attr_decode u_mem_attr_decode (
        .clk(clk), .rst_n(rst_n), .dram_base_i(DBASE), .dram_limit_i(DLIMIT),
        .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_is_store(req_is_store),
        .rsp_valid(rsp_valid), .rsp_route(rsp_route),
        .rsp_zero_read(rsp_zero_read), .rsp_drop_store(rsp_drop_store));

    function automatic exp_t model(logic [31:0] a, logic st, string tag);
        exp_t e;
        e.route = 2'd2; e.zero = 1'b0; e.drop = 1'b0; e.tag = tag;
        if (a >= DBASE && a < DLIMIT) e.route = (a >= m_cl) ? 2'd1 : 2'd0;
        else if (m_mode == 2'b10) begin
            e.route = 2'd3; e.zero = !st; e.drop = st;
        end else if (a <= 32'hFF && m_mode != 2'b01 && !st) begin
            e.route = 2'd3; e.zero = 1'b1;
        end
        return e;
    endfunction

    task automatic send(logic [31:0] a, logic st, string tag);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_is_store = st;
        sb.push_back(model(a, st, tag));
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    task automatic cfg(logic sel, logic [31:0] d);
        idle(1);
        cfg_wr_en = 1'b1; cfg_sel = sel; cfg_wdata = d;
        if (!sel) m_cl = {d[31:16], 16'h0};
        else m_mode = d[6:5];
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    // Monitor: pop and compare each response.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            n_cmp++;
            if (sb.size() == 0) begin
                n_bad++;
                $display("FAIL R2 unexpected response: actual valid=1 expected valid=0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (rsp_route !== e.route || rsp_zero_read !== e.zero ||
                    rsp_drop_store !== e.drop) begin
                    n_bad++;
                    $display("FAIL %s: actual route=%0d zero=%0b drop=%0b expected route=%0d zero=%0b drop=%0b",
                             e.tag, rsp_route, rsp_zero_read, rsp_drop_store,
                             e.route, e.zero, e.drop);
                end
            end
        end
    end

    initial begin
        m_cl = DLIMIT; m_mode = 2'b00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        n_cmp++;
        if (rsp_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset valid: actual %0b expected 0", rsp_valid);
        end
        send(32'h10FF_FFF0, 0, "R1 top of DRAM cached after reset");
        send(32'h1000_0000, 1, "R1 DRAM base cached");
        idle(3);
        cfg(0, 32'h10F0_1234);
        send(32'h10F0_0000, 0, "R4 aligned limit uncached");
        send(32'h10EF_FFFF, 0, "R3 below limit cached");
        send(32'h10FF_FFFF, 1, "R3 last DRAM byte uncached");
        send(32'h1100_0000, 0, "R9 first above DRAM to PCI");
        send(32'h0000_0000, 0, "R5 hole load zero");
        send(32'h0000_00FF, 0, "R5 hole end load zero");
        send(32'h0000_0100, 0, "R9 past hole PCI");
        send(32'h0000_0010, 1, "R5 hole store PCI");
        cfg(1, 32'h0000_0020);
        send(32'h0000_0080, 0, "R6 hole open load PCI");
        send(32'h2000_0000, 1, "R9 mode01 store PCI");
        cfg(1, 32'hFFFF_FF9F);
        send(32'h0000_0000, 0, "R10 other ctl bits ignored");
        cfg(1, 32'h0000_0040);
        send(32'h2000_0000, 0, "R7 apertures off load");
        send(32'h2000_0000, 1, "R7 apertures off store");
        send(32'h0000_0010, 1, "R7 hole store dropped");
        send(32'h1000_0000, 0, "R7 DRAM unaffected");
        send(32'h10F8_0000, 1, "R7 uncached unaffected");
        cfg(1, 32'h0000_0060);
        send(32'h0000_0000, 0, "R8 reserved hole load zero");
        send(32'h2000_0000, 1, "R8 reserved store PCI");
        send(32'h0000_0020, 1, "R8 reserved hole store PCI");
        idle(4);
        n_cmp++;
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL R2 missing responses: actual %0d pending expected 0", sb.size());
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL R2 watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule